// File: doc/BRIEF.md
# Looping ADSR Envelope Generator

This block shapes the loudness of one synthesizer voice. It walks an 8-bit amplitude through four phases: a rising attack, a decay down to a sustain level, a timed sustain plateau and a release back to silence. A pass begins on the rising edge of a trigger input. With loop mode set, the block ignores the trigger and starts a new pass by itself each time a release finishes. A 3-bit length input stretches every amplitude step, and a 3-bit shape selector picks one of eight preset envelopes. The preset is latched when a pass begins.

The amplitude moves one step per step period. The period is `(len_i + 1) * BASE_TICKS` clock cycles, so the length input scales the whole envelope in proportion. When the enable input is low, the output sits at full scale while the envelope keeps running internally. The oscillator and the PWM stage that consume the amplitude are outside this block.

Top module: `env_adsr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `amp_o` is 0 (with `en_i` high) and `busy_o` is 0.
- R2: The trigger and loop inputs each pass through two synchronizing flops. A low-to-high change of `trig_i` driven between two clock edges starts a pass on the third rising edge after it, and `busy_o` goes high there. A trigger held high does not start another pass.
- R3: After a pass begins, the amplitude changes only on step strobes. Strobes come every `(len_i + 1) * BASE_TICKS` cycles, and the first one arrives that many cycles after the start.
- R4: In attack, each step adds the attack increment and saturates at 255. Reaching 255 moves the machine to decay.
- R5: In decay, each step subtracts 16, never going below the sustain level. Reaching that level starts sustain, which holds the amplitude for a number of steps equal to the hold count and then enters release.
- R6: In release, each step subtracts the release decrement, never going below 0. Reaching 0 with loop mode off returns the machine to idle with `busy_o` low. In idle the amplitude is 0.
- R7: The preset for selector value s is: attack increment 64 >> s[1:0]; release decrement 8 if s[2] is 1, else 32; sustain level 96 if s[2] is 1, else 160; hold count 2 + s. The selector is latched at the start of each pass, and later changes take effect only at the next start.
- R8: With loop mode on, the trigger has no effect. From idle, a pass starts on the third edge after `loop_i` rises. When a release reaches 0, attack starts again at once, `busy_o` stays high, and the preset is re-latched.
- R9: A trigger edge during a pass (loop off) restarts attack from the current amplitude and restarts the step timer.
- R10: With `en_i` low, `amp_o` reads 255 whatever the envelope state. The envelope keeps advancing, and raising `en_i` shows its current amplitude at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Asynchronous trigger; a rising edge starts a pass |
| loop_i | input | 1 | Asynchronous loop mode select |
| en_i | input | 1 | Envelope enable; low forces full-scale output |
| len_i | input | 3 | Step-length multiplier minus one |
| shape_sel_i | input | 3 | Preset envelope selector |
| amp_o | output | 8 | Envelope amplitude |
| busy_o | output | 1 | High while a pass is in progress |

## Verification
A start takes effect on the third rising edge after the trigger or loop input is driven. Step n of a pass then lands on edge 3 + n·L, where L = (len_i + 1)·BASE_TICKS. A retrigger or loop-off edge driven mid-pass restarts the step count three edges later. `en_i` acts on `amp_o` in the same cycle with no register in between. The bench drives inputs at falling edges and counts rising edges from that point. It samples one time unit after the computed edge, so each check sees step n as it appears, before step n+1 arrives. One vector stops a single cycle before a step is due, to confirm the amplitude has not yet moved.

// File: rtl/env_pkg.sv
package env_pkg;

    localparam int AMP_W = 8;
    localparam int SEL_W = 3;
    localparam int LEN_W = 3;

    typedef logic [AMP_W-1:0] amp_t;
    localparam amp_t AMP_MAX = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ATTACK,
        ST_DECAY,
        ST_SUSTAIN,
        ST_RELEASE
    } env_state_e;

    typedef struct packed {
        amp_t atk_step;
        amp_t dec_step;
        amp_t rel_step;
        amp_t sus_level;
        amp_t hold_steps;
    } shape_t;

    // Preset shapes are derived from the selector bits rather than stored.
    function automatic shape_t shape_of(input logic [SEL_W-1:0] sel);
        shape_t s;
        s.atk_step   = amp_t'(64) >> sel[1:0];
        s.dec_step   = amp_t'(16);
        s.rel_step   = sel[2] ? amp_t'(8)  : amp_t'(32);
        s.sus_level  = sel[2] ? amp_t'(96) : amp_t'(160);
        s.hold_steps = amp_t'(2) + amp_t'(sel);
        return s;
    endfunction

    function automatic amp_t sat_add(input amp_t a, input amp_t b);
        logic [AMP_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[AMP_W] ? AMP_MAX : sum[AMP_W-1:0];
    endfunction

    // Subtract b from a, never going below lim.
    function automatic amp_t floor_sub(input amp_t a, input amp_t b, input amp_t lim);
        logic [AMP_W:0] gap;
        gap = {1'b0, a} - {1'b0, lim};
        if (gap[AMP_W] || (gap[AMP_W-1:0] <= b))
            return lim;
        return a - b;
    endfunction

endpackage

// File: rtl/env_sync.sv
module env_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/env_ticker.sv
module env_ticker #(
    parameter int BASE_TICKS = 256,
    parameter int LEN_W      = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             stb_o
);

    localparam int MAX_MULT = 1 << LEN_W;
    localparam int CNT_W    = $clog2(BASE_TICKS * MAX_MULT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((int'(len_i) + 1) * BASE_TICKS - 1);
    assign stb_o = run_i && (cnt_q == limit);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i || !run_i || stb_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/env_fsm.sv
module env_fsm
    import env_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             stb_i,
    input  logic             trig_rise_i,
    input  logic             loop_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             launch_o,
    output env_state_e       state_o,
    output amp_t             amp_o,
    output amp_t             sus_level_o
);

    env_state_e state_q, state_d;
    amp_t       amp_q, amp_d;
    amp_t       hold_q, hold_d;
    shape_t     shape_q;
    logic       launch;

    always_comb begin
        state_d = state_q;
        amp_d   = amp_q;
        hold_d  = hold_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (loop_i) launch = 1'b1;
            end
            ST_ATTACK: begin
                if (stb_i) begin
                    amp_d = sat_add(amp_q, shape_q.atk_step);
                    if (amp_d == AMP_MAX) state_d = ST_DECAY;
                end
            end
            ST_DECAY: begin
                if (stb_i) begin
                    amp_d = floor_sub(amp_q, shape_q.dec_step, shape_q.sus_level);
                    if (amp_d == shape_q.sus_level) begin
                        state_d = ST_SUSTAIN;
                        hold_d  = '0;
                    end
                end
            end
            ST_SUSTAIN: begin
                if (stb_i) begin
                    if (hold_q == shape_q.hold_steps - amp_t'(1))
                        state_d = ST_RELEASE;
                    else
                        hold_d = hold_q + amp_t'(1);
                end
            end
            ST_RELEASE: begin
                if (stb_i) begin
                    amp_d = floor_sub(amp_q, shape_q.rel_step, '0);
                    if (amp_d == '0) begin
                        if (loop_i) launch = 1'b1;
                        else        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (trig_rise_i && !loop_i) launch = 1'b1;
        if (launch) state_d = ST_ATTACK;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            amp_q   <= '0;
            hold_q  <= '0;
            shape_q <= shape_of('0);
        end else begin
            state_q <= state_d;
            amp_q   <= amp_d;
            hold_q  <= hold_d;
            if (launch) shape_q <= shape_of(sel_i);
        end
    end

    assign launch_o    = launch;
    assign state_o     = state_q;
    assign amp_o       = amp_q;
    assign sus_level_o = shape_q.sus_level;

endmodule

// File: rtl/env_adsr_gen.sv
module env_adsr_gen
    import env_pkg::*;
#(
    parameter int BASE_TICKS = 256
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             trig_i,
    input  logic             loop_i,
    input  logic             en_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [SEL_W-1:0] shape_sel_i,
    output logic [AMP_W-1:0] amp_o,
    output logic             busy_o
);

    logic       trig_s, loop_s, trig_prev_q, trig_rise;
    logic       step_stb, launch;
    env_state_e env_state;
    amp_t       env_amp, sus_level;

    env_sync #(.W(2), .STAGES(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({trig_i, loop_i}),
        .q_o   ({trig_s, loop_s})
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) trig_prev_q <= 1'b0;
        else       trig_prev_q <= trig_s;
    end

    assign trig_rise = trig_s && !trig_prev_q;

    env_ticker #(.BASE_TICKS(BASE_TICKS), .LEN_W(LEN_W)) u_ticker (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (busy_o),
        .restart_i (launch),
        .len_i     (len_i),
        .stb_o     (step_stb)
    );

    env_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .stb_i       (step_stb),
        .trig_rise_i (trig_rise),
        .loop_i      (loop_s),
        .sel_i       (shape_sel_i),
        .launch_o    (launch),
        .state_o     (env_state),
        .amp_o       (env_amp),
        .sus_level_o (sus_level)
    );

    assign busy_o = (env_state != ST_IDLE);
    assign amp_o  = en_i ? env_amp : AMP_MAX;

endmodule

// File: rtl/env_adsr_chk.sv
module env_adsr_chk
    import env_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       en_i,
    input logic [7:0] amp_o,
    input logic       busy_o,
    input env_state_e state_i,
    input amp_t       env_amp_i,
    input amp_t       sus_level_i,
    input logic       step_stb_i,
    input logic       loop_s_i
);

    // R1: reset clears the amplitude and the busy flag
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (env_amp_i == '0 && !busy_o));

    // R3: amplitude moves only after a step strobe
    p_step_gated_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(step_stb_i) |-> $stable(env_amp_i));

    // R4: attack never lowers the amplitude
    p_attack_rises_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_ATTACK && $past(state_i) == ST_ATTACK) |-> env_amp_i >= $past(env_amp_i));

    // R5: decay stays at or above the sustain level
    p_decay_floor_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_DECAY) |-> env_amp_i >= sus_level_i);

    // R6: release never raises the amplitude
    p_release_falls_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_RELEASE && $past(state_i) == ST_RELEASE) |-> env_amp_i <= $past(env_amp_i));

    // R6: idle output is silent when enabled
    p_idle_silent_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && en_i) |-> amp_o == '0);

    // R8: loop mode never lets a running pass fall back to idle
    p_loop_stays_busy_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (loop_s_i && busy_o) |=> busy_o);

endmodule

bind env_adsr_gen env_adsr_chk chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .en_i        (en_i),
    .amp_o       (amp_o),
    .busy_o      (busy_o),
    .state_i     (env_state),
    .env_amp_i   (env_amp),
    .sus_level_i (sus_level),
    .step_stb_i  (step_stb),
    .loop_s_i    (loop_s)
);

// File: tb/env_adsr_gen_tb_top.sv
module env_adsr_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;

    typedef struct packed {
        logic [2:0]  sel;
        logic [2:0]  len;
        logic [15:0] cyc;
        logic [7:0]  amp;
        logic        busy;
    } vec_t;

    // cyc = rising edges after the trigger is driven: 3 + n*(len+1)*BASE for step n
    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 3'd0, 16'd2,   8'd0,   1'b0},  // R2 not yet started
        '{3'd0, 3'd0, 16'd3,   8'd0,   1'b1},  // R2 started
        '{3'd0, 3'd0, 16'd5,   8'd64,  1'b1},  // R4 step 1
        '{3'd0, 3'd0, 16'd11,  8'd255, 1'b1},  // R4 saturate step 4
        '{3'd0, 3'd0, 16'd23,  8'd160, 1'b1},  // R5 sustain reached step 10
        '{3'd0, 3'd0, 16'd29,  8'd128, 1'b1},  // R5 hold 2 then release step 13
        '{3'd0, 3'd0, 16'd37,  8'd0,   1'b0},  // R6 idle step 17
        '{3'd5, 3'd3, 16'd67,  8'd255, 1'b1},  // R7 attack 32, step 8
        '{3'd5, 3'd3, 16'd147, 8'd96,  1'b1},  // R7 sustain 96, step 18
        '{3'd5, 3'd3, 16'd211, 8'd88,  1'b1},  // R7 release 8, step 26
        '{3'd5, 3'd3, 16'd299, 8'd0,   1'b0},  // R6 idle step 37
        '{3'd0, 3'd7, 16'd18,  8'd0,   1'b1},  // R3 one cycle before step
        '{3'd0, 3'd7, 16'd19,  8'd64,  1'b1},  // R3 step 1 at L=16
        '{3'd3, 3'd0, 16'd7,   8'd16,  1'b1}   // R7 attack 8, step 2
    };

    logic       clk = 1'b0;
    logic       rst, trig, loop_m, en;
    logic [2:0] len, sel;
    logic [7:0] amp;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    env_adsr_gen #(.BASE_TICKS(BASE)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .trig_i      (trig),
        .loop_i      (loop_m),
        .en_i        (en),
        .len_i       (len),
        .shape_sel_i (sel),
        .amp_o       (amp),
        .busy_o      (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] s, input logic [2:0] l, input logic e);
        @(negedge clk);
        rst = 1'b1; trig = 1'b0; loop_m = 1'b0; en = e; sel = s; len = l;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; trig = 1'b0; loop_m = 1'b0; en = 1'b1; sel = '0; len = '0;

        // R1: reset state, inside reset and right after release
        repeat (2) @(posedge clk);
        #1;
        chk("R1 amp in reset", amp, 0);
        chk("R1 busy in reset", busy, 0);
        @(negedge clk); rst = 1'b0;
        edges(1);
        chk("R1 amp after reset", amp, 0);
        chk("R1 busy after reset", busy, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            do_reset(VECS[i].sel, VECS[i].len, 1'b1);
            @(negedge clk); trig = 1'b1;
            edges(int'(VECS[i].cyc));
            chk($sformatf("R2-vec%0d amp", i), amp, int'(VECS[i].amp));
            chk($sformatf("R2-vec%0d busy", i), busy, int'(VECS[i].busy));
        end

        // R9: retrigger during release restarts attack from current amplitude
        do_reset(3'd0, 3'd0, 1'b1);
        @(negedge clk); trig = 1'b1;
        edges(5);
        @(negedge clk); trig = 1'b0;
        edges(24);
        chk("R9 release before retrigger", amp, 128);
        @(negedge clk); trig = 1'b1;
        edges(5);
        chk("R9 attack from current level", amp, 160);
        chk("R9 busy", busy, 1);

        // R8: trigger ignored while looping
        do_reset(3'd0, 3'd0, 1'b1);
        @(negedge clk); loop_m = 1'b1;
        edges(13);
        chk("R8 loop start decay", amp, 239);
        @(negedge clk); trig = 1'b1;
        edges(6);
        chk("R8 trigger ignored", amp, 191);

        // R7/R8: preset latched per pass, loop restarts after release
        do_reset(3'd0, 3'd0, 1'b1);
        @(negedge clk); loop_m = 1'b1;
        edges(3);
        @(negedge clk); sel = 3'd3;
        edges(8);
        chk("R7 latched preset kept", amp, 255);
        edges(26);
        chk("R8 release end amp", amp, 0);
        chk("R8 busy across restart", busy, 1);
        edges(2);
        chk("R7 new preset after restart", amp, 8);

        // R10: enable off forces full scale, envelope keeps running
        do_reset(3'd0, 3'd0, 1'b0);
        edges(1);
        chk("R10 idle disabled amp", amp, 255);
        chk("R10 idle disabled busy", busy, 0);
        @(negedge clk); trig = 1'b1;
        edges(5);
        chk("R10 running disabled amp", amp, 255);
        edges(7);
        @(negedge clk); en = 1'b1;
        #1;
        chk("R10 enable shows envelope", amp, 255);
        edges(1);
        chk("R10 envelope advanced while off", amp, 239);

        // R2: held trigger does not start a second pass
        edges(40);
        chk("R2 held trigger no restart", busy, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule